// File: doc/BRIEF.md
# SPI Interrupt Flag Register

This block holds the event flags of an SPI peripheral that has transmit and receive FIFOs. The SPI datapath reports events and levels to it: a finished receive, the receive FIFO being full, the transmit FIFO being full, a transmit underrun and a frame error. Three control levels shape how the flags behave: module enable, framed-mode enable and ignore-underrun mode. The block combines these inputs into one 32-bit status word. Software reads that word, and clears flags in it, over a simple strobe-based register port.

Some flags are sticky and software clears them by writing a one. Others follow their source level directly. The underrun flag has two behaviours. In normal framed operation it latches. In ignore-underrun mode it becomes a live indicator that never needs clearing. A 32-bit enable input masks the status word, and the interrupt output is high while any enabled flag is set.

Top module: `spi_irq_flags`

## Requirements
- R1: After reset, every flag is 0, a read at the register offset returns 0 and `irq` is 0.
- R2: Bit 30 (receive overflow) sets when `rx_done` is high in a cycle where `rx_full` is also high. An `rx_done` while `rx_full` is low leaves bit 30 unchanged.
- R3: Bit 30 clears only when a write of 1 to bit 30 hits offset 0x20. Writing 0 to bit 30 leaves it unchanged.
- R4: Bit 15 (frame error) sets on a `frame_err` pulse only while `frm_en` is 1. With `frm_en` at 0 the pulse is ignored. The flag holds until a write of 1 to bit 15 clears it, and writing 0 leaves it unchanged.
- R5: If a set event and a write-one-to-clear of the same flag land in the same cycle, the flag ends up set.
- R6: With `mod_on`=1, `frm_en`=1 and `ign_und`=0, a `tx_underrun` pulse latches bit 27. Bit 27 then holds until a write of 1 to bit 27 clears it. With `frm_en`=0 the pulse is ignored.
- R7: While `mod_on` is 0, bit 27 reads 0, and any latched underrun is discarded. Turning `mod_on` back to 1 does not bring the old value back.
- R8: With `ign_und`=1 (and `mod_on`, `frm_en` at 1), bit 27 equals the present `tx_underrun` level. It does not latch and drops with no write.
- R9: Bit 4 equals `tx_full` and bit 0 equals `rx_full` at all times. Neither latches.
- R10: All bits other than 30, 27, 15, 4 and 0 read 0. Writes to those bits, and writes to any other address, change no flag.
- R11: `irq` is the OR over all bits of (status word AND `irq_en`).
- R12: `reg_rdata` carries the status word in the same cycle as `reg_rd` is high with `reg_addr`=0x20, and is 0 otherwise. A flag cleared by a write reads 0 on the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register port address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data, ones clear flags |
| reg_rdata | output | 32 | Read data, 0 when not read |
| rx_done | input | 1 | Pulse: a receive data unit completed |
| rx_full | input | 1 | Receive FIFO full level |
| tx_full | input | 1 | Transmit FIFO full level |
| tx_underrun | input | 1 | Transmit underrun condition |
| frame_err | input | 1 | Pulse: frame error detected |
| mod_on | input | 1 | Module enable |
| frm_en | input | 1 | Framed-mode enable |
| ign_und | input | 1 | Ignore-underrun mode |
| irq_en | input | 32 | Per-bit interrupt enable mask |
| irq | output | 1 | Interrupt request |

## Verification
Several rules are checked on every cycle: the overflow set and clear, the hold of a set overflow flag with no clear, the frame-error gating by framed mode, the underrun latch, the zeroing of bit 27 while the module is off, the zeros on the unimplemented bits and the idle read bus. The bench scenarios show the rest. These are the set-wins race between an event and a clear, the discarding of a latched underrun across an off/on cycle, the live tracking of the underrun level in ignore mode, writes to the wrong address and the interrupt masking under several enable patterns.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   localparam int unsigned REG_W    = 32;
   localparam int unsigned BIT_ROV  = 30;
   localparam int unsigned BIT_TUR  = 27;
   localparam int unsigned BIT_FERR = 15;
   localparam int unsigned BIT_TXF  = 4;
   localparam int unsigned BIT_RXF  = 0;
   localparam logic [REG_W-1:0] IMPL_MASK = (32'h1 << BIT_ROV) | (32'h1 << BIT_TUR) |
                                             (32'h1 << BIT_FERR) | (32'h1 << BIT_TXF) |
                                             (32'h1 << BIT_RXF);

   typedef struct packed {
      logic rov;
      logic tur;
      logic ferr;
      logic txf;
      logic rxf;
   } flag_set_t;

   typedef struct packed {
      logic rov;
      logic tur;
      logic ferr;
   } clr_set_t;
endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic kill_i,
   output logic q_o
);
   logic q_r;
   logic q_nxt;

   generate
      if (SET_WINS) begin : g_set_wins
         always_comb q_nxt = set_i | (q_r & ~clr_i);
      end else begin : g_clr_wins
         always_comb q_nxt = (set_i | q_r) & ~clr_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_r <= 1'b0;
      else if (kill_i) q_r <= 1'b0;
      else             q_r <= q_nxt;
   end

   assign q_o = q_r;
endmodule

// File: rtl/spi_irq_underrun.sv
module spi_irq_underrun #(
   parameter bit SET_WINS       = 1'b1,
   parameter bit SUPPORT_IGNORE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mod_on,
   input  logic frm_en,
   input  logic ign_und,
   input  logic cond_i,
   input  logic clr_i,
   output logic flag_o
);
   logic stored;
   logic set_s;
   logic kill_s;

   generate
      if (SUPPORT_IGNORE) begin : g_ign
         logic live;
         assign set_s  = frm_en & ~ign_und & cond_i;
         assign kill_s = ~mod_on | ign_und;
         assign live   = frm_en & cond_i;
         assign flag_o = mod_on & (ign_und ? live : stored);
      end else begin : g_noign
         logic unused_ign;
         assign unused_ign = ign_und;
         assign set_s  = frm_en & cond_i;
         assign kill_s = ~mod_on;
         assign flag_o = mod_on & stored;
      end
   endgenerate

   spi_irq_sticky #(.SET_WINS(SET_WINS)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_s),
      .clr_i  (clr_i),
      .kill_i (kill_s),
      .q_o    (stored)
   );
endmodule

// File: rtl/spi_irq_regif.sv
module spi_irq_regif
   import spi_irq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned REG_OFFSET = 32'h20
) (
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_W-1:0]  reg_wdata,
   input  flag_set_t         flags_i,
   input  logic [REG_W-1:0]  irq_en,
   output clr_set_t          clr_o,
   output logic [REG_W-1:0]  view_o,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] OFF_A = ADDR_W'(REG_OFFSET);

   logic hit;
   logic wr_hit;
   logic rd_hit;
   logic unused_wdata;

   assign hit    = (reg_addr == OFF_A);
   assign wr_hit = reg_wr & hit;
   assign rd_hit = reg_rd & hit;

   assign clr_o.rov  = wr_hit & reg_wdata[BIT_ROV];
   assign clr_o.tur  = wr_hit & reg_wdata[BIT_TUR];
   assign clr_o.ferr = wr_hit & reg_wdata[BIT_FERR];
   assign unused_wdata = ^(reg_wdata & ~IMPL_MASK);

   always_comb begin
      view_o           = '0;
      view_o[BIT_ROV]  = flags_i.rov;
      view_o[BIT_TUR]  = flags_i.tur;
      view_o[BIT_FERR] = flags_i.ferr;
      view_o[BIT_TXF]  = flags_i.txf;
      view_o[BIT_RXF]  = flags_i.rxf;
   end

   assign reg_rdata = rd_hit ? view_o : '0;
   assign irq       = |(view_o & irq_en);
endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags
   import spi_irq_pkg::*;
#(
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned REG_OFFSET     = 32'h20,
   parameter bit          SET_WINS       = 1'b1,
   parameter bit          SUPPORT_IGNORE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              rx_done,
   input  logic              rx_full,
   input  logic              tx_full,
   input  logic              tx_underrun,
   input  logic              frame_err,
   input  logic              mod_on,
   input  logic              frm_en,
   input  logic              ign_und,
   input  logic [31:0]       irq_en,
   output logic              irq
);
   localparam longint unsigned ADDR_SPAN = 64'd1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
         $error("spi_irq_flags: ADDR_W out of range");
      end
      if (longint'(REG_OFFSET) >= ADDR_SPAN) begin : g_bad_off
         $error("spi_irq_flags: REG_OFFSET does not fit ADDR_W");
      end
      if (REG_W != 32) begin : g_bad_w
         $error("spi_irq_flags: register width must be 32");
      end
   endgenerate

   flag_set_t        flags;
   clr_set_t         clr;
   logic [REG_W-1:0] flag_view;

   spi_irq_sticky #(.SET_WINS(SET_WINS)) u_rov (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (rx_done & rx_full),
      .clr_i  (clr.rov),
      .kill_i (1'b0),
      .q_o    (flags.rov)
   );

   spi_irq_sticky #(.SET_WINS(SET_WINS)) u_ferr (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (frame_err & frm_en),
      .clr_i  (clr.ferr),
      .kill_i (1'b0),
      .q_o    (flags.ferr)
   );

   spi_irq_underrun #(.SET_WINS(SET_WINS), .SUPPORT_IGNORE(SUPPORT_IGNORE)) u_tur (
      .clk     (clk),
      .rst_n   (rst_n),
      .mod_on  (mod_on),
      .frm_en  (frm_en),
      .ign_und (ign_und),
      .cond_i  (tx_underrun),
      .clr_i   (clr.tur),
      .flag_o  (flags.tur)
   );

   assign flags.txf = tx_full;
   assign flags.rxf = rx_full;

   spi_irq_regif #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_regif (
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_wdata (reg_wdata),
      .flags_i   (flags),
      .irq_en    (irq_en),
      .clr_o     (clr),
      .view_o    (flag_view),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );
endmodule

// File: rtl/spi_irq_flags_chk.sv
module spi_irq_flags_chk
   import spi_irq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned REG_OFFSET = 32'h20
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic              rx_done,
   input logic              rx_full,
   input logic              tx_underrun,
   input logic              frame_err,
   input logic              mod_on,
   input logic              frm_en,
   input logic              ign_und,
   input logic [31:0]       view
);
   logic hit;
   assign hit = (reg_addr == ADDR_W'(REG_OFFSET));

   assert_ovf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_full) |=> view[BIT_ROV]);

   assert_ovf_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && hit && reg_wdata[BIT_ROV] && !(rx_done && rx_full)) |=> !view[BIT_ROV]);

   assert_ovf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (view[BIT_ROV] && !(reg_wr && hit && reg_wdata[BIT_ROV])) |=> view[BIT_ROV]);

   assert_ferr_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!view[BIT_FERR] && !(frame_err && frm_en)) |=> !view[BIT_FERR]);

   assert_und_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_on && frm_en && !ign_und && tx_underrun) |=> (view[BIT_TUR] || !mod_on || ign_und));

   assert_off_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_on |-> !view[BIT_TUR]);

   assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~IMPL_MASK) == 32'h0);

   assert_idle_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd && hit) |-> (reg_rdata == 32'h0));
endmodule

bind spi_irq_flags spi_irq_flags_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_addr    (reg_addr),
   .reg_wr      (reg_wr),
   .reg_rd      (reg_rd),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .rx_done     (rx_done),
   .rx_full     (rx_full),
   .tx_underrun (tx_underrun),
   .frame_err   (frame_err),
   .mod_on      (mod_on),
   .frm_en      (frm_en),
   .ign_und     (ign_und),
   .view        (flag_view)
);

// File: tb/tb_spi_irq_flags.sv
`timescale 1ns/1ps
module tb_spi_irq_flags;
   localparam logic [7:0] OFF = 8'h20;
   localparam logic [31:0] B_ROV = 32'h4000_0000;
   localparam logic [31:0] B_TUR = 32'h0800_0000;
   localparam logic [31:0] B_FE  = 32'h0000_8000;
   localparam logic [31:0] B_TXF = 32'h0000_0010;
   localparam logic [31:0] B_RXF = 32'h0000_0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = OFF;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        rx_done = 0, rx_full = 0, tx_full = 0, tx_underrun = 0, frame_err = 0;
   logic        mod_on = 0, frm_en = 0, ign_und = 0;
   logic [31:0] irq_en = '0;
   logic        irq;
   int          checks = 0, errors = 0;
   bit          done = 0;

   always #4 clk = ~clk;

   spi_irq_flags dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_done(rx_done), .rx_full(rx_full),
      .tx_full(tx_full), .tx_underrun(tx_underrun), .frame_err(frame_err), .mod_on(mod_on),
      .frm_en(frm_en), .ign_und(ign_und), .irq_en(irq_en), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic rd(output logic [31:0] v);
      reg_addr = OFF; reg_rd = 1'b1; #1;
      v = reg_rdata;
      reg_rd = 1'b0; #1;
   endtask

   task automatic wr(input logic [31:0] d, input logic [7:0] a = OFF);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0; reg_wdata = '0; reg_addr = OFF;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(v);
      chk("R1 reset rdata", v, 32'h0);
      chk("R1 reset irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_overflow();
      logic [31:0] v;
      rx_done = 1; tick(); rx_done = 0; #1;
      rd(v); chk("R2 done without full", v & B_ROV, 32'h0);
      rx_full = 1; rx_done = 1; tick(); rx_done = 0; #1;
      rd(v); chk("R2 done while full", v & B_ROV, B_ROV);
      wr(~B_ROV & 32'h0); rd(v); chk("R3 write zero keeps", v & B_ROV, B_ROV);
      wr(B_ROV); rd(v); chk("R3 write one clears, R12 reads 0 next", v & B_ROV, 32'h0);
      rx_full = 0; #1;
   endtask

   task automatic t_frame_err();
      logic [31:0] v;
      frm_en = 0; frame_err = 1; tick(); frame_err = 0; #1;
      rd(v); chk("R4 ignored when not framed", v & B_FE, 32'h0);
      frm_en = 1; frame_err = 1; tick(); frame_err = 0; #1;
      rd(v); chk("R4 set when framed", v & B_FE, B_FE);
      wr(32'h0); rd(v); chk("R4 write zero keeps", v & B_FE, B_FE);
      wr(B_FE); rd(v); chk("R4 cleared", v & B_FE, 32'h0);
      // R5: set event and clear write in the same cycle
      frame_err = 1; wr(B_FE); frame_err = 0; #1;
      rd(v); chk("R5 set wins over clear", v & B_FE, B_FE);
      wr(B_FE);
   endtask

   task automatic t_underrun_latched();
      logic [31:0] v;
      mod_on = 1; frm_en = 0; ign_und = 0;
      tx_underrun = 1; tick(); tx_underrun = 0; #1;
      rd(v); chk("R6 ignored when not framed", v & B_TUR, 32'h0);
      frm_en = 1; tx_underrun = 1; tick(); tx_underrun = 0; tick();
      rd(v); chk("R6 latched after pulse", v & B_TUR, B_TUR);
      wr(B_TUR); rd(v); chk("R6 cleared by write one", v & B_TUR, 32'h0);
      tx_underrun = 1; wr(B_TUR); tx_underrun = 0; #1;
      rd(v); chk("R5 underrun set wins", v & B_TUR, B_TUR);
   endtask

   task automatic t_underrun_off();
      logic [31:0] v;
      mod_on = 0; #1;
      rd(v); chk("R7 off reads zero", v & B_TUR, 32'h0);
      tick(); mod_on = 1; #1;
      rd(v); chk("R7 latched value discarded", v & B_TUR, 32'h0);
   endtask

   task automatic t_underrun_ignore();
      logic [31:0] v;
      ign_und = 1; tx_underrun = 1; tick();
      rd(v); chk("R8 live high", v & B_TUR, B_TUR);
      tx_underrun = 0; #1;
      rd(v); chk("R8 drops without write", v & B_TUR, 32'h0);
      tx_underrun = 1; tick(); tx_underrun = 0; tick();
      rd(v); chk("R8 no latch", v & B_TUR, 32'h0);
      ign_und = 0;
   endtask

   task automatic t_live_bits();
      logic [31:0] v;
      tx_full = 1; rx_full = 0; #1;
      rd(v); chk("R9 tx full only", v, B_TXF);
      tx_full = 0; rx_full = 1; #1;
      rd(v); chk("R9 rx full only", v, B_RXF);
      rx_full = 0; #1;
      rd(v); chk("R9 both clear", v, 32'h0);
   endtask

   task automatic t_unimpl_and_addr();
      logic [31:0] v;
      wr(32'hFFFF_FFFF); rd(v); chk("R10 unimplemented read zero", v, 32'h0);
      frame_err = 1; tick(); frame_err = 0; #1;
      wr(B_FE, 8'h24); rd(v); chk("R10 other address ignored", v & B_FE, B_FE);
      reg_addr = 8'h24; reg_rd = 1; #1; v = reg_rdata; reg_rd = 0; reg_addr = OFF; #1;
      chk("R12 read elsewhere returns 0", v, 32'h0);
   endtask

   task automatic t_irq();
      irq_en = B_FE; #1; chk("R11 enabled flag raises irq", {31'b0, irq}, 32'h1);
      irq_en = ~B_FE; #1; chk("R11 masked flag", {31'b0, irq}, 32'h0);
      wr(B_FE);
      irq_en = B_TXF; tx_full = 1; #1; chk("R11 live bit irq", {31'b0, irq}, 32'h1);
      tx_full = 0; #1; chk("R11 irq drops", {31'b0, irq}, 32'h0);
      irq_en = '0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tick();
      t_reset();
      t_overflow();
      t_frame_err();
      t_underrun_latched();
      t_underrun_off();
      t_underrun_ignore();
      t_live_bits();
      t_unimpl_and_addr();
      t_irq();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule